// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit performs one indivisible load-operate-store on a 32-bit or 64-bit memory location. A requester hands over an operation code, a size code, a resolved byte address, the index of the base register that produced the address, an operand, a destination register index and two ordering flags. The unit reads the location and combines the old contents with the operand through one of eight operations. It writes the combined value back and returns the *old* contents on a response channel, together with a destination-write enable.

The memory side is a simple synchronous request/acknowledge port on a 64-bit data path with byte enables. A lock output is raised from the moment the read is requested until the write is acknowledged, so that no other master can get between the two accesses. Ordering attributes (acquire, release, tag-check) travel with each access. A release operation waits for an external "older stores drained" indication before reading. An acquire operation holds back its response until the store has been acknowledged. Without acquire, the response may be offered while the store is still outstanding.

Top module: `atomic_rmw`

## Requirements
- R1: A request is taken only in a cycle where `reqValid` and `reqReady` are both high, and `reqReady` is high only while the unit is idle. Once `rspValid` is high it stays high, with `rspData` and `rspFault` unchanged, until a cycle with `rspReady` high.
- R2: The value written back is f(old, operand) for `reqOp`: 0 add, 1 old AND NOT operand, 2 XOR, 3 OR, 4 signed maximum, 5 signed minimum, 6 unsigned maximum, 7 unsigned minimum.
- R3: `rspData` carries the memory value from before the update, zero-extended: for a 32-bit access bits 63:32 are zero.
- R4: Size code `reqSize` 2 selects 32-bit and 3 selects 64-bit data. A 32-bit access uses only operand bits 31:0 and takes bit 31 as the sign. It writes `memBe` 8'h0F when address bit 2 is 0 (data in bits 31:0) and 8'h0F0 shifted form 8'hF0 when address bit 2 is 1 (data in bits 63:32). A 64-bit access writes `memBe` 8'hFF.
- R5: `rspDestWe` is 0 when `reqDest` is 31 and 1 otherwise for a fault-free operation. The store still takes place when `reqDest` is 31.
- R6: During every memory access of an operation, `memAcqAttr` equals `reqAcq` AND (`reqDest` != 31), and `memRelAttr` equals `reqRel`.
- R7: With `reqRel` set, the read request is not raised until `drainDone` is high. With `reqRel` clear, `drainDone` has no effect.
- R8: With the acquire attribute set, `rspValid` rises only after the write has been acknowledged. Without it, `rspValid` rises as soon as the read data is captured, while the write is still pending.
- R9: `memLock` is high in every cycle with `memReq` high, and once high it stays high until the cycle in which the write is acknowledged.
- R10: An address not aligned to the access size, or a base index of 31 with address bits 3:0 not zero, gives `rspFault` = 1, `rspData` = 0 and `rspDestWe` = 0, and raises no memory request.
- R11: A size code of 0 or 1 gives `rspFault` = 2, with no memory request and `rspDestWe` = 0. This check takes priority over the alignment fault.
- R12: `memTagChk` is 1 during accesses of an operation whose base index is not 31, and 0 when it is 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Unit idle and able to take a request |
| reqOp | input | 3 | Operation code |
| reqSize | input | 2 | Size code (2: 32-bit, 3: 64-bit) |
| reqAddr | input | ADDR_W | Resolved byte address |
| reqOperand | input | DATA_W | Operand combined with memory |
| reqDest | input | IDX_W | Destination register index (31 = none) |
| reqBase | input | IDX_W | Base register index (31 = stack pointer) |
| reqAcq | input | 1 | Acquire requested |
| reqRel | input | 1 | Release requested |
| rspValid | output | 1 | Response offered |
| rspReady | input | 1 | Response taken |
| rspData | output | DATA_W | Old memory value, zero-extended |
| rspDestWe | output | 1 | Destination register write enable |
| rspDest | output | IDX_W | Destination register index |
| rspFault | output | 2 | 0 none, 1 alignment, 2 illegal size |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | ADDR_W | Byte address of the access |
| memWdata | output | DATA_W | Write data, lane placed |
| memBe | output | DATA_W/8 | Write byte enables |
| memAck | input | 1 | Access accepted; read data valid |
| memRdata | input | DATA_W | Read data |
| memLock | output | 1 | Memory held locked |
| memAcqAttr | output | 1 | Acquire attribute of the operation |
| memRelAttr | output | 1 | Release attribute of the operation |
| memTagChk | output | 1 | Access is tag-checked |
| drainDone | input | 1 | Older stores have drained |

## Verification
The bound checker watches the port-level sequencing on every cycle. It checks that the lock stays continuous from read to write acknowledge and that a release read never starts while older stores are still pending. It also checks that a stalled response holds its value, that an acquire response never overlaps a pending write, that faulted responses stay off the memory port, and that write enables take one of the three legal shapes. The operation results, the returned pre-update value and its zero-extension, lane placement, and the attribute values only show up in the bench's scenarios. The same holds for early responses without acquire and for the fault codes, which the bench compares against its own memory model and reference arithmetic.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_CLR  = 3'd1,
    OP_XOR  = 3'd2,
    OP_OR   = 3'd3,
    OP_SMAX = 3'd4,
    OP_SMIN = 3'd5,
    OP_UMAX = 3'd6,
    OP_UMIN = 3'd7
  } amo_op_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_ALIGN = 2'd1,
    FLT_SIZE  = 2'd2
  } amo_fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RESP
  } amo_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;   // latch the accepted request
    logic capRead;  // latch read data and form the store value
  } amo_strobe_t;

endpackage

// File: rtl/atomic_rmw_alu.sv
module atomic_rmw_alu #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [2:0]        op,
  input  logic              wide,
  input  logic [DATA_W-1:0] oldVal,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result
);
  import atomic_rmw_pkg::*;

  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] aU, bU, aS, bS, raw;
  logic              sGreater, uGreater;

  always_comb begin
    // unsigned views: narrow data zero-extended
    aU = wide ? oldVal  : {{HALF_W{1'b0}}, oldVal[HALF_W-1:0]};
    bU = wide ? operand : {{HALF_W{1'b0}}, operand[HALF_W-1:0]};
    // signed views: narrow data sign-extended from its top bit
    aS = wide ? oldVal  : {{HALF_W{oldVal[HALF_W-1]}},  oldVal[HALF_W-1:0]};
    bS = wide ? operand : {{HALF_W{operand[HALF_W-1]}}, operand[HALF_W-1:0]};
    sGreater = $signed(aS) > $signed(bS);
    uGreater = aU > bU;
    case (amo_op_e'(op))
      OP_ADD:  raw = aU + bU;
      OP_CLR:  raw = aU & ~bU;
      OP_XOR:  raw = aU ^ bU;
      OP_OR:   raw = aU | bU;
      OP_SMAX: raw = sGreater ? aU : bU;
      OP_SMIN: raw = sGreater ? bU : aU;
      OP_UMAX: raw = uGreater ? aU : bU;
      default: raw = uGreater ? bU : aU;
    endcase
    result = wide ? raw : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
  end

endmodule

// File: rtl/atomic_rmw_dpath.sv
module atomic_rmw_dpath #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned IDX_W       = 5,
  parameter int unsigned SP_ALIGN_LG = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  atomic_rmw_pkg::amo_strobe_t strobe,
  input  logic [2:0]             reqOp,
  input  logic [1:0]             reqSize,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [DATA_W-1:0]      reqOperand,
  input  logic [IDX_W-1:0]       reqDest,
  input  logic [IDX_W-1:0]       reqBase,
  input  logic                   reqAcq,
  input  logic                   reqRel,
  input  logic [DATA_W-1:0]      memRdata,
  output logic [1:0]             reqFault,
  output logic                   acqFlag,
  output logic                   relFlag,
  output logic                   tagFlag,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [DATA_W-1:0]      memWdata,
  output logic [DATA_W/8-1:0]    memBe,
  output logic [DATA_W-1:0]      rspData,
  output logic                   rspDestWe,
  output logic [IDX_W-1:0]       rspDest,
  output logic [1:0]             rspFault
);
  import atomic_rmw_pkg::*;

  localparam int unsigned HALF_W   = DATA_W / 2;
  localparam int unsigned BE_W     = DATA_W / 8;
  localparam int unsigned WIDE_LG  = $clog2(BE_W);
  localparam int unsigned LANE_BIT = WIDE_LG - 1;
  localparam logic [IDX_W-1:0] NO_REG = '1;

  logic [2:0]        opR;
  logic              wideR;
  logic [ADDR_W-1:0] addrR;
  logic [DATA_W-1:0] operandR;
  logic [DATA_W-1:0] oldR;
  logic [DATA_W-1:0] resultR;
  logic [IDX_W-1:0]  destR;
  logic [1:0]        faultR;
  logic              acqR, relR, tagR;

  logic              misSize, misStack;
  logic [DATA_W-1:0] oldLane;
  logic [DATA_W-1:0] aluOut;

  // fault classification of the offered request
  always_comb begin
    misSize  = reqSize[0] ? (reqAddr[WIDE_LG-1:0] != '0)
                          : (reqAddr[LANE_BIT-1:0] != '0);
    misStack = (reqBase == NO_REG) && (reqAddr[SP_ALIGN_LG-1:0] != '0);
    if (!reqSize[1])               reqFault = FLT_SIZE;
    else if (misSize || misStack)  reqFault = FLT_ALIGN;
    else                           reqFault = FLT_NONE;
  end

  // lane extraction of the read word
  always_comb begin
    if (wideR)
      oldLane = memRdata;
    else if (addrR[LANE_BIT])
      oldLane = {{HALF_W{1'b0}}, memRdata[DATA_W-1:HALF_W]};
    else
      oldLane = {{HALF_W{1'b0}}, memRdata[HALF_W-1:0]};
  end

  atomic_rmw_alu #(.DATA_W(DATA_W)) i_alu (
    .op      (opR),
    .wide    (wideR),
    .oldVal  (oldLane),
    .operand (operandR),
    .result  (aluOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR      <= '0;
      wideR    <= 1'b0;
      addrR    <= '0;
      operandR <= '0;
      oldR     <= '0;
      resultR  <= '0;
      destR    <= NO_REG;
      faultR   <= FLT_NONE;
      acqR     <= 1'b0;
      relR     <= 1'b0;
      tagR     <= 1'b0;
    end else begin
      if (strobe.capReq) begin
        opR      <= reqOp;
        wideR    <= reqSize[0];
        addrR    <= reqAddr;
        operandR <= reqSize[0] ? reqOperand
                               : {{HALF_W{1'b0}}, reqOperand[HALF_W-1:0]};
        oldR     <= '0;
        resultR  <= '0;
        destR    <= reqDest;
        faultR   <= reqFault;
        acqR     <= reqAcq && (reqDest != NO_REG);
        relR     <= reqRel;
        tagR     <= reqBase != NO_REG;
      end
      if (strobe.capRead) begin
        oldR    <= oldLane;
        resultR <= aluOut;
      end
    end
  end

  always_comb begin
    memAddr  = addrR;
    memWdata = wideR ? resultR : {2{resultR[HALF_W-1:0]}};
    if (wideR)                 memBe = '1;
    else if (addrR[LANE_BIT])  memBe = {{(BE_W/2){1'b1}}, {(BE_W/2){1'b0}}};
    else                       memBe = {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
    rspData   = oldR;
    rspDest   = destR;
    rspFault  = faultR;
    rspDestWe = (destR != NO_REG) && (faultR == FLT_NONE);
    acqFlag   = acqR;
    relFlag   = relR;
    tagFlag   = tagR;
  end

endmodule

// File: rtl/atomic_rmw_ctrl.sv
module atomic_rmw_ctrl (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqFault,
  input  logic       acqFlag,
  input  logic       relFlag,
  input  logic       drainDone,
  input  logic       memAck,
  input  logic       rspReady,
  output logic       reqReady,
  output logic       memReq,
  output logic       memWe,
  output logic       memLock,
  output logic       rspValid,
  output atomic_rmw_pkg::amo_strobe_t strobe
);
  import atomic_rmw_pkg::*;

  amo_state_e state, stateNext;
  logic       readIssued;  // read already raised, hold it regardless of drain
  logic       rspTaken;    // early response accepted during the write
  logic       readGo;

  always_comb begin
    reqReady = state == ST_IDLE;
    readGo   = readIssued || !relFlag || drainDone;
    memReq   = ((state == ST_READ) && readGo) || (state == ST_WRITE);
    memWe    = state == ST_WRITE;
    memLock  = memReq;
    rspValid = (state == ST_RESP) ||
               ((state == ST_WRITE) && !acqFlag && !rspTaken);
    strobe.capReq  = (state == ST_IDLE) && reqValid;
    strobe.capRead = (state == ST_READ) && memReq && memAck;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:
        if (reqValid) stateNext = (reqFault != 2'd0) ? ST_RESP : ST_READ;
      ST_READ:
        if (memReq && memAck) stateNext = ST_WRITE;
      ST_WRITE:
        if (memAck)
          stateNext = (rspTaken || (rspValid && rspReady)) ? ST_IDLE : ST_RESP;
      default:
        if (rspReady) stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      readIssued <= 1'b0;
      rspTaken   <= 1'b0;
    end else begin
      state      <= stateNext;
      readIssued <= (state == ST_READ) && memReq && !memAck;
      rspTaken   <= (state == ST_WRITE) && !memAck &&
                    (rspTaken || (rspValid && rspReady));
    end
  end

endmodule

// File: rtl/atomic_rmw.sv
module atomic_rmw #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned IDX_W       = 5,
  parameter int unsigned SP_ALIGN_LG = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [2:0]          reqOp,
  input  logic [1:0]          reqSize,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqOperand,
  input  logic [IDX_W-1:0]    reqDest,
  input  logic [IDX_W-1:0]    reqBase,
  input  logic                reqAcq,
  input  logic                reqRel,
  output logic                rspValid,
  input  logic                rspReady,
  output logic [DATA_W-1:0]   rspData,
  output logic                rspDestWe,
  output logic [IDX_W-1:0]    rspDest,
  output logic [1:0]          rspFault,
  output logic                memReq,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [DATA_W/8-1:0] memBe,
  input  logic                memAck,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                memLock,
  output logic                memAcqAttr,
  output logic                memRelAttr,
  output logic                memTagChk,
  input  logic                drainDone
);
  import atomic_rmw_pkg::*;

  amo_strobe_t strobe;
  logic [1:0]  reqFault;
  logic        acqFlag, relFlag, tagFlag;

  atomic_rmw_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqFault  (reqFault),
    .acqFlag   (acqFlag),
    .relFlag   (relFlag),
    .drainDone (drainDone),
    .memAck    (memAck),
    .rspReady  (rspReady),
    .reqReady  (reqReady),
    .memReq    (memReq),
    .memWe     (memWe),
    .memLock   (memLock),
    .rspValid  (rspValid),
    .strobe    (strobe)
  );

  atomic_rmw_dpath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .IDX_W       (IDX_W),
    .SP_ALIGN_LG (SP_ALIGN_LG)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqOp      (reqOp),
    .reqSize    (reqSize),
    .reqAddr    (reqAddr),
    .reqOperand (reqOperand),
    .reqDest    (reqDest),
    .reqBase    (reqBase),
    .reqAcq     (reqAcq),
    .reqRel     (reqRel),
    .memRdata   (memRdata),
    .reqFault   (reqFault),
    .acqFlag    (acqFlag),
    .relFlag    (relFlag),
    .tagFlag    (tagFlag),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memBe      (memBe),
    .rspData    (rspData),
    .rspDestWe  (rspDestWe),
    .rspDest    (rspDest),
    .rspFault   (rspFault)
  );

  assign memAcqAttr = acqFlag;
  assign memRelAttr = relFlag;
  assign memTagChk  = tagFlag;

endmodule

// File: rtl/atomic_rmw_chk.sv
module atomic_rmw_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W  = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqReady,
  input logic                rspValid,
  input logic                rspReady,
  input logic [DATA_W-1:0]   rspData,
  input logic [1:0]          rspFault,
  input logic [IDX_W-1:0]    rspDest,
  input logic                rspDestWe,
  input logic                memReq,
  input logic                memWe,
  input logic                memAck,
  input logic [DATA_W/8-1:0] memBe,
  input logic                memLock,
  input logic                memAcqAttr,
  input logic                memRelAttr,
  input logic                drainDone
);
  localparam int unsigned BE_W = DATA_W / 8;
  localparam logic [BE_W-1:0] BE_LO = {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
  localparam logic [BE_W-1:0] BE_HI = {{(BE_W/2){1'b1}}, {(BE_W/2){1'b0}}};

  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memLock && !rspValid));

  a_r1_rsp_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData) && $stable(rspFault)));

  a_r9_lock_until_write_ack: assert property (@(posedge clk) disable iff (!rstN)
    (memLock && !(memReq && memWe && memAck)) |=> memLock);

  a_r7_drain_before_read: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memReq) && !memWe && memRelAttr) |-> drainDone);

  a_r8_acq_rsp_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && memAcqAttr) |-> !memReq);

  a_r10_fault_no_access: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspFault != 2'd0)) |-> (!memReq && !rspDestWe));

  a_r4_be_shape: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> ((memBe == '1) || (memBe == BE_LO) || (memBe == BE_HI)));

  a_r5_no_dest_write: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspDest == '1)) |-> !rspDestWe);

endmodule

bind atomic_rmw atomic_rmw_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqReady   (reqReady),
  .rspValid   (rspValid),
  .rspReady   (rspReady),
  .rspData    (rspData),
  .rspFault   (rspFault),
  .rspDest    (rspDest),
  .rspDestWe  (rspDestWe),
  .memReq     (memReq),
  .memWe      (memWe),
  .memAck     (memAck),
  .memBe      (memBe),
  .memLock    (memLock),
  .memAcqAttr (memAcqAttr),
  .memRelAttr (memRelAttr),
  .drainDone  (drainDone)
);

// File: tb/test_atomic_rmw.sv
`timescale 1ns/1ps
module test_atomic_rmw;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;
  localparam int IDX_W  = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [2:0]        reqOp = '0;
  logic [1:0]        reqSize = 2'd3;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [63:0]       reqOperand = '0;
  logic [4:0]        reqDest = '0;
  logic [4:0]        reqBase = '0;
  logic              reqAcq = 1'b0;
  logic              reqRel = 1'b0;
  logic              rspValid;
  logic              rspReady = 1'b1;
  logic [63:0]       rspData;
  logic              rspDestWe;
  logic [4:0]        rspDest;
  logic [1:0]        rspFault;
  logic              memReq, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [63:0]       memWdata;
  logic [7:0]        memBe;
  logic              memAck = 1'b0;
  logic [63:0]       memRdata = '0;
  logic              memLock, memAcqAttr, memRelAttr, memTagChk;
  logic              drainDone = 1'b1;

  always #4 clk = ~clk;

  atomic_rmw #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_atomic_rmw (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqSize(reqSize), .reqAddr(reqAddr), .reqOperand(reqOperand),
    .reqDest(reqDest), .reqBase(reqBase), .reqAcq(reqAcq), .reqRel(reqRel),
    .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData),
    .rspDestWe(rspDestWe), .rspDest(rspDest), .rspFault(rspFault),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memBe(memBe), .memAck(memAck), .memRdata(memRdata), .memLock(memLock),
    .memAcqAttr(memAcqAttr), .memRelAttr(memRelAttr), .memTagChk(memTagChk),
    .drainDone(drainDone)
  );

  typedef struct {
    logic [63:0] data;
    logic        we;
    logic [1:0]  fault;
    int          timing;  // 0 no check, 1 write acked before response, 2 response before write ack
  } exp_t;

  exp_t        expQ[$];
  logic [63:0] mem [0:15];
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;

  int  memLat = 0;
  int  stallN = 0;
  int  latCnt = 0;
  int  stallCnt = 0;
  int  readsSeen = 0;
  int  reqCycles = 0;
  bit  wrDone = 0;
  bit  seen = 0;
  bit  prevStall = 0;
  logic [63:0] prevData;
  logic        curAcq, curRel, curTag;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic sgt(input logic [63:0] a, input logic [63:0] b, input logic w);
    if (w) return $signed(a) > $signed(b);
    return $signed(a[31:0]) > $signed(b[31:0]);
  endfunction

  function automatic logic [63:0] refOp(input logic [2:0] op, input logic w,
                                        input logic [63:0] o, input logic [63:0] v);
    logic [63:0] a, b, r;
    a = w ? o : {32'h0, o[31:0]};
    b = w ? v : {32'h0, v[31:0]};
    case (op)
      3'd0: r = a + b;
      3'd1: r = a & ~b;
      3'd2: r = a ^ b;
      3'd3: r = a | b;
      3'd4: r = sgt(a, b, w) ? a : b;
      3'd5: r = sgt(a, b, w) ? b : a;
      3'd6: r = (a > b) ? a : b;
      default: r = (a > b) ? b : a;
    endcase
    return w ? r : {32'h0, r[31:0]};
  endfunction

  // memory model and response monitor share one process to fix their order
  initial begin
    forever begin
      @(negedge clk);
      if (!finished) begin
        memAck = 1'b0;
        if (memReq) begin
          reqCycles++;
          if (!memLock) chk("R9 lock with request", 64'(memLock), 64'd1);
          if (!memWe) begin
            readsSeen++;
            if (memRelAttr && !drainDone) chk("R7 read before drain", 64'd1, 64'd0);
          end
          if (latCnt >= memLat) begin
            chk("R6 acquire attribute", 64'(memAcqAttr), 64'(curAcq));
            chk("R6 release attribute", 64'(memRelAttr), 64'(curRel));
            chk("R12 tag-check attribute", 64'(memTagChk), 64'(curTag));
            memAck = 1'b1;
            latCnt = 0;
            if (memWe) begin
              for (int k = 0; k < 8; k++)
                if (memBe[k]) mem[memAddr[6:3]][k*8 +: 8] = memWdata[k*8 +: 8];
              wrDone = 1;
            end else begin
              memRdata = mem[memAddr[6:3]];
            end
          end else begin
            latCnt++;
          end
        end
        // response side: decide ready for the coming edge first
        if (rspValid && stallCnt < stallN) begin
          rspReady = 1'b0;
          stallCnt++;
        end else begin
          rspReady = 1'b1;
        end
        if (prevStall) begin
          chk("R1 response held", 64'(rspValid), 64'd1);
          chk("R1 response data stable", rspData, prevData);
        end
        prevStall = rspValid && !rspReady;
        prevData  = rspData;
        if (rspValid && !seen) begin
          seen = 1;
          if (expQ.size() > 0) begin
            if (expQ[0].timing == 1) chk("R8 acquire waits for write ack", 64'(wrDone), 64'd1);
            if (expQ[0].timing == 2) chk("R8 early response without acquire", 64'(wrDone), 64'd0);
          end
        end
        if (rspValid && rspReady) begin
          if (expQ.size() == 0) begin
            chk("R1 unexpected response", 64'd1, 64'd0);
          end else begin
            exp_t e;
            e = expQ.pop_front();
            chk("R3 returned old value", rspData, e.data);
            chk("R5 destination write enable", 64'(rspDestWe), 64'(e.we));
            chk("R10 R11 fault code", 64'(rspFault), 64'(e.fault));
          end
          seen = 0;
          stallCnt = 0;
        end
      end
    end
  end

  task automatic sendReq(input logic [2:0] op, input logic [1:0] sz, input logic [15:0] addr,
                         input logic [63:0] opnd, input logic [4:0] dest, input logic [4:0] base,
                         input logic acq, input logic rel);
    exp_t        e;
    logic        w;
    logic [63:0] word, oldv, r, newWord;
    logic        faultAlign;
    @(negedge clk);
    reqOp = op; reqSize = sz; reqAddr = addr; reqOperand = opnd;
    reqDest = dest; reqBase = base; reqAcq = acq; reqRel = rel;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    w = sz[0];
    word = mem[addr[6:3]];
    oldv = w ? word : (addr[2] ? {32'h0, word[63:32]} : {32'h0, word[31:0]});
    r = refOp(op, w, oldv, opnd);
    newWord = w ? r : (addr[2] ? {r[31:0], word[31:0]} : {word[63:32], r[31:0]});
    faultAlign = (w ? (addr[2:0] != 0) : (addr[1:0] != 0)) || (base == 5'd31 && addr[3:0] != 0);
    e.fault = !sz[1] ? 2'd2 : (faultAlign ? 2'd1 : 2'd0);
    e.data  = (e.fault == 0) ? oldv : 64'h0;
    e.we    = (e.fault == 0) && (dest != 5'd31);
    curAcq  = acq && (dest != 5'd31);
    curRel  = rel;
    curTag  = base != 5'd31;
    e.timing = (e.fault != 0) ? 0 : (curAcq ? 1 : (memLat > 0 ? 2 : 0));
    expQ.push_back(e);
    wrDone = 0; readsSeen = 0; reqCycles = 0; latCnt = 0;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R1 not ready while busy", 64'(reqReady), 64'd0);
    while (!reqReady || rspValid) @(negedge clk);
    if (e.fault != 0) begin
      chk("R10 R11 no memory request on fault", 64'(reqCycles), 64'd0);
      chk("R10 R11 memory untouched", mem[addr[6:3]], word);
    end else begin
      chk(w ? "R2 stored result 64-bit" : "R4 stored result 32-bit lane", mem[addr[6:3]], newWord);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++)
      mem[i] = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h1111_0000_0000_1111);
    mem[1] = 64'hFFFF_FFFF_FFFF_FFF0;
    mem[2] = 64'h0000_0003_8000_0001;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", 64'(reqReady), 64'd1);
    chk("R1 reset no response", 64'(rspValid), 64'd0);
    chk("R9 reset no request or lock", 64'({memReq, memLock}), 64'd0);

    // R2: all operations, 64-bit, signed negative memory value
    for (int op = 0; op < 8; op++) begin
      mem[1] = 64'hFFFF_FFFF_FFFF_FFF0;
      sendReq(3'(op), 2'd3, 16'h0008, 64'd5, 5'd3, 5'd2, 1'b0, 1'b0);
    end
    for (int op = 0; op < 8; op++)
      sendReq(3'(op), 2'd3, 16'h0020, 64'hF0F0_1234_0FF0_8765, 5'd4, 5'd1, 1'b0, 1'b0);

    // R4: 32-bit in both lanes with garbage upper operand bits, sign at bit 31
    for (int op = 0; op < 8; op++) begin
      mem[2] = 64'h0000_0003_8000_0001;
      sendReq(3'(op), 2'd2, 16'h0010, 64'hDEAD_BEEF_0000_0007, 5'd5, 5'd2, 1'b0, 1'b0);
      mem[2] = 64'h8000_0001_0000_0002;
      sendReq(3'(op), 2'd2, 16'h0014, 64'h1234_5678_7FFF_FFFF, 5'd6, 5'd2, 1'b0, 1'b0);
    end

    // R5 R6: no destination, acquire suppressed
    sendReq(3'd0, 2'd3, 16'h0028, 64'd9, 5'd31, 5'd2, 1'b1, 1'b0);
    sendReq(3'd2, 2'd2, 16'h002C, 64'hFF, 5'd31, 5'd2, 1'b1, 1'b1);

    // R8 R12: latency, acquire vs early response, stack-pointer base
    memLat = 2;
    sendReq(3'd3, 2'd3, 16'h0030, 64'h10, 5'd7, 5'd31, 1'b1, 1'b0);
    sendReq(3'd3, 2'd3, 16'h0038, 64'h20, 5'd8, 5'd31, 1'b0, 1'b0);
    stallN = 3;
    sendReq(3'd0, 2'd2, 16'h0040, 64'h1, 5'd9, 5'd3, 1'b0, 1'b0);
    sendReq(3'd6, 2'd3, 16'h0048, 64'h2, 5'd9, 5'd3, 1'b1, 1'b0);
    stallN = 0;
    memLat = 1;

    // R7: release waits for drain, non-release ignores it
    drainDone = 1'b0;
    fork
      sendReq(3'd0, 2'd3, 16'h0050, 64'd1, 5'd10, 5'd2, 1'b0, 1'b1);
      begin
        repeat (10) @(negedge clk);
        chk("R7 no read before drain", 64'(readsSeen), 64'd0);
        drainDone = 1'b1;
      end
    join
    drainDone = 1'b0;
    sendReq(3'd0, 2'd3, 16'h0058, 64'd1, 5'd11, 5'd2, 1'b0, 1'b0);
    drainDone = 1'b1;

    // R10: alignment faults
    sendReq(3'd0, 2'd3, 16'h0064, 64'd1, 5'd12, 5'd2, 1'b0, 1'b0);
    sendReq(3'd0, 2'd2, 16'h0062, 64'd1, 5'd12, 5'd2, 1'b0, 1'b0);
    sendReq(3'd0, 2'd3, 16'h0068, 64'd1, 5'd12, 5'd31, 1'b0, 1'b0);
    sendReq(3'd0, 2'd3, 16'h0070, 64'd1, 5'd12, 5'd31, 1'b0, 1'b0);
    // R11: illegal sizes, size fault before alignment fault
    sendReq(3'd0, 2'd1, 16'h0060, 64'd1, 5'd13, 5'd2, 1'b0, 1'b0);
    sendReq(3'd0, 2'd0, 16'h0061, 64'd1, 5'd13, 5'd2, 1'b0, 1'b0);

    repeat (4) @(negedge clk);
    chk("R1 all responses seen", 64'(expQ.size()), 64'd0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule